// File: doc/BRIEF.md
# Shader Input Thread Window Scheduler

This block sits inside a shader unit and keeps a window of resident shader work. Work enters as groups of four inputs. A group holds either vertices or fragments, and both kinds share the same window. Each resident group has a small state machine with four states. FREE means the slot is empty. READY means the group may be issued. BUSY means the group is executing its current burst of instructions. WAIT means the group is blocked on a texture result or another dependency.

Each cycle the scheduler chooses one READY group and issues it to fetch and execute a fixed number of instructions (`N_INSTR`). The choice follows a rotating priority that starts just after the group issued last. The execution side reports the end of every burst through a completion port, with a code that says what happens next:
- code 00 yields, and the group returns to READY.
- code 01 blocks the group on a texture result, and it moves to WAIT.
- code 10 finishes its program, and the slot is freed.
- code 11 is treated as a yield.

Texture results carry the group tag. They may come back in any order, and each one wakes only the group it names. A group leaves the window only through the finish code, and only then can a new group be allocated into its slot.

The slot transitions are named as follows:
- FREE→READY on allocate.
- READY→BUSY on issue.
- BUSY→READY on yield.
- BUSY→WAIT on texture wait.
- BUSY→FREE on finish.
- WAIT→READY on wakeup.

Apart from the slot states, the scheduler keeps one rotation pointer, plus registered issue and retire outputs.

Top module: `tws_top`

## Requirements
- R1: After reset every slot is FREE, `issue_valid` and `retire_valid` are low, `alloc_ready` is high and `alloc_grp` is 0.
- R2: `alloc_grp` always names the lowest-numbered FREE slot, and `alloc_ready` is low exactly when no slot is FREE. A group accepted at a clock edge is READY in the next cycle.
- R3: Each issue names one group and presents it one clock edge after the cycle in which it was selected. An issue carries the stored kind of the group (0 = vertex, 1 = fragment) and `issue_ninstr` equal to `N_INSTR`. Vertex and fragment groups issue back to back with no idle cycle between them.
- R4: The search for the next group to issue starts at the slot after the one issued last and wraps from the highest slot to slot 0. After reset the search starts at slot 0.
- R5: While `issue_hold` is high nothing is issued, and READY groups stay READY.
- R6: A completion on a BUSY group moves it according to `done_code`:
  - 2'b00 to READY.
  - 2'b01 to WAIT.
  - 2'b10 to FREE.
  - 2'b11 to READY.
- R7: A WAIT group is never issued. A wakeup on `wake_grp` moves only that group to READY, whatever order the wakeups arrive in.
- R8: In any cycle with no READY group (or with hold high), `issue_valid` is low in the next cycle.
- R9: A finish completion raises `retire_valid` for one cycle in the next cycle, with `retire_grp` naming the group. Only after that can the slot be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to place a new group in the window |
| alloc_kind | input | 1 | Kind of the new group: 0 vertex, 1 fragment |
| alloc_ready | output | 1 | At least one slot is FREE |
| alloc_grp | output | GW | Slot the new group will occupy |
| issue_hold | input | 1 | Execution side cannot take an issue this cycle |
| issue_valid | output | 1 | A group is issued this cycle |
| issue_grp | output | GW | Tag of the issued group |
| issue_kind | output | 1 | Kind of the issued group |
| issue_ninstr | output | CW | Instructions to fetch and execute for this issue |
| done_valid | input | 1 | End of an instruction burst for a group |
| done_grp | input | GW | Tag of the group that ended its burst |
| done_code | input | 2 | 00 yield, 01 texture wait, 10 finish, 11 yield |
| wake_valid | input | 1 | Texture result returned |
| wake_grp | input | GW | Tag carried by the returned texture request |
| retire_valid | output | 1 | A group has left the window |
| retire_grp | output | GW | Tag of the retired group |

## Verification
The slot assertions take for granted the following about the block's inputs:
- A completion only names a group that is BUSY.
- A wakeup only names a group that is in WAIT.
- An allocation only lands on a FREE slot.

A texture return that arrives before its group has entered WAIT is therefore outside the contract. The stimulus keeps its own model of each group's state and drives a completion or a wakeup only for a group that this model shows in the matching state. It never presents two events for the same group in one cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [1:0] {
        S_FREE  = 2'd0,
        S_READY = 2'd1,
        S_BUSY  = 2'd2,
        S_WAIT  = 2'd3
    } slot_st_t;

    localparam logic [1:0] DONE_YIELD  = 2'b00;
    localparam logic [1:0] DONE_WAIT   = 2'b01;
    localparam logic [1:0] DONE_FINISH = 2'b10;

    localparam logic KIND_VTX = 1'b0;
    localparam logic KIND_FRG = 1'b1;

endpackage

// File: rtl/tws_slot.sv
module tws_slot
    import tws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc_hit,
    input  logic       alloc_kind,
    input  logic       issue_hit,
    input  logic       done_hit,
    input  logic [1:0] done_code,
    input  logic       wake_hit,
    output slot_st_t   st_o,
    output logic       kind_o
);

    slot_st_t st_q, st_d;
    logic     kind_q;

    // State register and stored kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_FREE;
            kind_q <= KIND_VTX;
        end else begin
            st_q <= st_d;
            if (alloc_hit) begin
                kind_q <= alloc_kind;
            end
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_FREE: begin
                if (alloc_hit) st_d = S_READY;
            end
            S_READY: begin
                if (issue_hit) st_d = S_BUSY;
            end
            S_BUSY: begin
                if (done_hit) begin
                    case (done_code)
                        DONE_WAIT:   st_d = S_WAIT;
                        DONE_FINISH: st_d = S_FREE;
                        default:     st_d = S_READY;
                    endcase
                end
            end
            S_WAIT: begin
                if (wake_hit) st_d = S_READY;
            end
            default: st_d = S_FREE;
        endcase
    end

    // Outputs
    assign st_o   = st_q;
    assign kind_o = kind_q;

    // The picker only grants groups that are READY (R7)
    p_issue_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hit |-> st_q == S_READY);

    // Allocation only lands on a FREE slot (R2)
    p_alloc_into_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_hit |-> st_q == S_FREE);

    // Completion only for a BUSY group (R6)
    p_done_on_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_hit |-> st_q == S_BUSY);

    // Wakeup only for a WAIT group (R7)
    p_wake_on_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |-> st_q == S_WAIT);

endmodule

// File: rtl/tws_rr_pick.sv
module tws_rr_pick #(
    parameter int GROUPS = 8,
    localparam int GW = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] req,
    input  logic              adv,
    output logic [GROUPS-1:0] gnt,
    output logic [GW-1:0]     gnt_idx,
    output logic              any
);

    logic [GW-1:0] ptr_q;

    // Rotating search starting at ptr_q
    always_comb begin
        int idx;
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        idx     = 0;
        for (int i = 0; i < GROUPS; i++) begin
            idx = int'(ptr_q) + i;
            if (idx >= GROUPS) idx = idx - GROUPS;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = GW'(idx);
            end
        end
    end

    // Pointer moves past the group just issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (int'(gnt_idx) == GROUPS - 1) ? '0 : gnt_idx + GW'(1);
        end
    end

    p_grant_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_grant_when_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> any);

endmodule

// File: rtl/tws_top.sv
module tws_top
    import tws_pkg::*;
#(
    parameter int GROUPS  = 8,
    parameter int N_INSTR = 4,
    localparam int GW = $clog2(GROUPS),
    localparam int CW = $clog2(N_INSTR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_kind,
    output logic          alloc_ready,
    output logic [GW-1:0] alloc_grp,
    input  logic          issue_hold,
    output logic          issue_valid,
    output logic [GW-1:0] issue_grp,
    output logic          issue_kind,
    output logic [CW-1:0] issue_ninstr,
    input  logic          done_valid,
    input  logic [GW-1:0] done_grp,
    input  logic [1:0]    done_code,
    input  logic          wake_valid,
    input  logic [GW-1:0] wake_grp,
    output logic          retire_valid,
    output logic [GW-1:0] retire_grp
);

    slot_st_t          st_arr [GROUPS];
    logic [GROUPS-1:0] kind_vec;
    logic [GROUPS-1:0] ready_vec;
    logic [GROUPS-1:0] free_vec;
    logic [GROUPS-1:0] alloc_hit;
    logic [GROUPS-1:0] issue_hit;
    logic [GROUPS-1:0] done_hit;
    logic [GROUPS-1:0] wake_hit;
    logic [GROUPS-1:0] gnt;
    logic [GW-1:0]     gnt_idx;
    logic              gnt_any;
    logic              adv;

    assign adv = gnt_any && !issue_hold;

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_slot
            assign ready_vec[g] = (st_arr[g] == S_READY);
            assign free_vec[g]  = (st_arr[g] == S_FREE);
            assign alloc_hit[g] = alloc_valid && alloc_ready && (alloc_grp == GW'(g));
            assign issue_hit[g] = gnt[g] && !issue_hold;
            assign done_hit[g]  = done_valid && (done_grp == GW'(g));
            assign wake_hit[g]  = wake_valid && (wake_grp == GW'(g));

            tws_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_hit  (alloc_hit[g]),
                .alloc_kind (alloc_kind),
                .issue_hit  (issue_hit[g]),
                .done_hit   (done_hit[g]),
                .done_code  (done_code),
                .wake_hit   (wake_hit[g]),
                .st_o       (st_arr[g]),
                .kind_o     (kind_vec[g])
            );
        end
    endgenerate

    // Lowest free slot
    always_comb begin
        alloc_grp = '0;
        for (int i = GROUPS - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_grp = GW'(i);
        end
    end
    assign alloc_ready = |free_vec;

    tws_rr_pick #(.GROUPS(GROUPS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ready_vec),
        .adv     (adv),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (gnt_any)
    );

    // Registered issue and retire outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid  <= 1'b0;
            issue_grp    <= '0;
            issue_kind   <= KIND_VTX;
            retire_valid <= 1'b0;
            retire_grp   <= '0;
        end else begin
            issue_valid  <= adv;
            issue_grp    <= gnt_idx;
            issue_kind   <= kind_vec[gnt_idx];
            retire_valid <= done_valid && (done_code == DONE_FINISH);
            retire_grp   <= done_grp;
        end
    end

    assign issue_ninstr = CW'(N_INSTR);

    p_issue_follows_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready_vec && !issue_hold) |=> issue_valid);

    p_idle_no_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ready_vec) |=> !issue_valid);

    p_hold_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hold |=> !issue_valid);

    p_retire_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> $past(done_valid));

endmodule

// File: tb/sim_tws_top.sv
module sim_tws_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alloc_valid;
    logic       alloc_kind;
    logic       alloc_ready;
    logic [1:0] alloc_grp;
    logic       issue_hold;
    logic       issue_valid;
    logic [1:0] issue_grp;
    logic       issue_kind;
    logic [2:0] issue_ninstr;
    logic       done_valid;
    logic [1:0] done_grp;
    logic [1:0] done_code;
    logic       wake_valid;
    logic [1:0] wake_grp;
    logic       retire_valid;
    logic [1:0] retire_grp;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    tws_top #(.GROUPS(4), .N_INSTR(4)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_valid  (alloc_valid),
        .alloc_kind   (alloc_kind),
        .alloc_ready  (alloc_ready),
        .alloc_grp    (alloc_grp),
        .issue_hold   (issue_hold),
        .issue_valid  (issue_valid),
        .issue_grp    (issue_grp),
        .issue_kind   (issue_kind),
        .issue_ninstr (issue_ninstr),
        .done_valid   (done_valid),
        .done_grp     (done_grp),
        .done_code    (done_code),
        .wake_valid   (wake_valid),
        .wake_grp     (wake_grp),
        .retire_valid (retire_valid),
        .retire_grp   (retire_grp)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_issue(string req, int grp, int kind);
        check(req, "issue_valid", int'(issue_valid), 1);
        check(req, "issue_grp", int'(issue_grp), grp);
        check(req, "issue_kind", int'(issue_kind), kind);
        check("R3", "issue_ninstr", int'(issue_ninstr), 4);
    endtask

    task automatic complete(int grp, int code);
        done_valid = 1'b1;
        done_grp   = 2'(grp);
        done_code  = 2'(code);
        step();
        done_valid = 1'b0;
    endtask

    task automatic wake(int grp);
        wake_valid = 1'b1;
        wake_grp   = 2'(grp);
        step();
        wake_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        alloc_valid = 1'b0; alloc_kind = 1'b0; issue_hold = 1'b1;
        done_valid = 1'b0; done_grp = '0; done_code = '0;
        wake_valid = 1'b0; wake_grp = '0;
        step(); step();
        rst_n = 1'b1;
        step();
        check("R1", "issue_valid", int'(issue_valid), 0);
        check("R1", "retire_valid", int'(retire_valid), 0);
        check("R1", "alloc_ready", int'(alloc_ready), 1);
        check("R1", "alloc_grp", int'(alloc_grp), 0);
    endtask

    // Fill the window with alternating kinds, then issue in slot order
    task automatic t_fill();
        for (int g = 0; g < 4; g++) begin
            check("R2", "alloc_grp", int'(alloc_grp), g);
            alloc_valid = 1'b1;
            alloc_kind  = 1'(g);
            step();
        end
        alloc_valid = 1'b0;
        check("R2", "alloc_ready full", int'(alloc_ready), 0);
        step(); step();
        check("R5", "issue_valid under hold", int'(issue_valid), 0);
        issue_hold = 1'b0;
        for (int g = 0; g < 4; g++) begin
            step();
            expect_issue("R3", g, g % 2);
        end
        step();
        check("R8", "issue_valid idle", int'(issue_valid), 0);
    endtask

    // Rotation after the last issued group; code 11 acts as yield
    task automatic t_rotation();
        issue_hold = 1'b1;
        complete(2, 0);
        complete(0, 3);
        issue_hold = 1'b0;
        step(); expect_issue("R4", 0, 0);
        step(); expect_issue("R6", 2, 0);
        step(); check("R8", "issue_valid idle", int'(issue_valid), 0);
        issue_hold = 1'b1;
        complete(0, 0);
        complete(1, 0);
        complete(3, 0);
        issue_hold = 1'b0;
        step(); expect_issue("R4", 3, 1);
        step(); expect_issue("R4", 0, 0);
        step(); expect_issue("R4", 1, 1);
        step(); check("R8", "issue_valid idle", int'(issue_valid), 0);
    endtask

    // Blocked groups, woken out of order
    task automatic t_texture();
        complete(1, 1);
        complete(3, 1);
        step(); step();
        check("R7", "blocked not issued", int'(issue_valid), 0);
        wake(3);
        check("R7", "issue one cycle after wake", int'(issue_valid), 0);
        step(); expect_issue("R7", 3, 1);
        step(); check("R7", "group 1 still blocked", int'(issue_valid), 0);
        wake(1);
        step(); expect_issue("R7", 1, 1);
        step(); check("R8", "issue_valid idle", int'(issue_valid), 0);
    endtask

    // Finish frees a slot, which is then reused
    task automatic t_retire();
        check("R9", "alloc_ready before finish", int'(alloc_ready), 0);
        complete(2, 2);
        check("R9", "retire_valid", int'(retire_valid), 1);
        check("R9", "retire_grp", int'(retire_grp), 2);
        check("R9", "alloc_ready after finish", int'(alloc_ready), 1);
        check("R2", "alloc_grp reuse", int'(alloc_grp), 2);
        check("R6", "finish not issued", int'(issue_valid), 0);
        alloc_valid = 1'b1;
        alloc_kind  = 1'b1;
        step();
        alloc_valid = 1'b0;
        check("R9", "retire pulse ends", int'(retire_valid), 0);
        check("R2", "alloc_ready full again", int'(alloc_ready), 0);
        step(); expect_issue("R3", 2, 1);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_rotation();
        t_texture();
        t_retire();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule